// File: doc/BRIEF.md
# Per-Port Operating Mode Resolver

This block decides, for each port of a multi-port Ethernet PHY, which line functions are active. Each function has two sources: a configuration pin that is captured while reset is held, and a bit from the management registers. Some functions turn on when either source asks for them. Autonegotiation runs only when both sources allow it. When a port runs in 100BASE-FX fiber mode, a fixed set of controls is forced and the matching register bits are ignored.

The shared configuration pins are captured into holding flops on every clock edge while reset is low. After reset is released, later movement on those pins has no effect. The autonegotiation pin is the exception. It is a live input that passes through a two-stage synchronizer. A rising edge on it gives a one-clock restart pulse on each copper port that has autonegotiation enabled. Every resolved control is registered and is driven to a defined default while reset is asserted.

Top module: `port_mode_resolver`

## Requirements
- R1: While `rst_n` is low, after a clock edge, every port shows these values:
  - low: `fiber_o`, `fef_o`, `scr_byp_o`, `an_en_o`, `sd_o`, `carrier_o`, `an_restart_o`
  - high: `mlt3_o`, `ten_o`, `link_fix_o`
- R2: For port p, `fiber_o[p]` is the OR of `reg_fiber_i[p]` and `strap_fiber_i[p]` as captured during reset. It updates one clock after a register change.
- R3: On a fiber port, the outputs are forced to these values, whatever `reg_fef_i`, `reg_scr_byp_i`, `reg_an_en_i` and `reg_ten_en_i` hold:
  - high: `fef_o`, `scr_byp_o`, `sd_o` enable path
  - low: `mlt3_o`, `an_en_o`, `ten_o`
- R4: `sd_o[p]` equals `sig_det_i[p]`, registered, on a fiber port. It is low on a copper port, whatever `sig_det_i[p]` does.
- R5: `carrier_o[p]` is the OR of the captured carrier pin and `reg_carrier_i[p]`, in both modes.
- R6: On a copper port, `an_en_o[p]` is the AND of the synchronized autonegotiation pin and `reg_an_en_i[p]`. A pin change reaches the output on the third clock edge.
- R7: A low-to-high transition of `strap_autoneg_i` gives `an_restart_o[p]` high for exactly one clock, on the third edge after the change. This happens only on copper ports with `reg_an_en_i[p]` high. A pin held high gives no further pulses. A pin held high through reset gives no pulse.
- R8: On a copper port, `scr_byp_o[p]` is the OR of the captured bypass pin and `reg_scr_byp_i[p]`.
- R9: `link_fix_o[p]` is the OR of the captured link-fix pin and `reg_link_fix_i[p]`, in both modes.
- R10: After reset is released, changes on `strap_fiber_i`, `strap_carrier_i`, `strap_scr_byp_i` and `strap_link_fix_i` have no effect on any output until the next reset.
- R11: On a copper port, `mlt3_o[p]` is high, `fef_o[p]` follows `reg_fef_i[p]` and `ten_o[p]` follows `reg_ten_en_i[p]`. Each register input reaches its output one clock after it changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration pins are captured while it is low |
| strap_fiber_i | input | NPORT | Per-port fiber-select configuration pins |
| strap_carrier_i | input | 1 | Shared carrier-integrity configuration pin |
| strap_autoneg_i | input | 1 | Live autonegotiation permit and restart pin |
| strap_scr_byp_i | input | 1 | Shared scrambler-bypass configuration pin |
| strap_link_fix_i | input | 1 | Shared enhanced link-integrity configuration pin |
| reg_fiber_i | input | NPORT | Register fiber-select bits |
| reg_carrier_i | input | NPORT | Register carrier-integrity bits |
| reg_an_en_i | input | NPORT | Register autonegotiation-enable bits |
| reg_scr_byp_i | input | NPORT | Register scrambler-bypass bits |
| reg_link_fix_i | input | NPORT | Register enhanced link-integrity bits |
| reg_fef_i | input | NPORT | Register far-end-fault enable bits |
| reg_ten_en_i | input | NPORT | Register 10BASE-T enable bits |
| sig_det_i | input | NPORT | Fiber signal-detect inputs |
| fiber_o | output | NPORT | Port runs in fiber mode |
| fef_o | output | NPORT | Far-end fault signalling enabled |
| mlt3_o | output | NPORT | MLT-3 line coding enabled |
| scr_byp_o | output | NPORT | Scrambler and descrambler bypassed |
| an_en_o | output | NPORT | Autonegotiation enabled |
| sd_o | output | NPORT | Gated signal-detect |
| ten_o | output | NPORT | 10BASE-T operation allowed |
| carrier_o | output | NPORT | Carrier integrity enabled |
| link_fix_o | output | NPORT | Enhanced link integrity enabled |
| an_restart_o | output | NPORT | One-clock autonegotiation restart pulse |

## Verification
A captured pin that is wrong, or that is sampled again after reset, shows at the ports one clock after release. It appears as a steady wrong level on every port that uses that pin, and it stays wrong until the next reset. A fault in the synchronizer shows up as the wrong latency from pin to `an_en_o`, or as a restart pulse that is missing, repeated or spurious. Either one is visible within three clocks of a pin edge. A wrong fiber decision on a port corrupts six outputs of that port at once, on the edge that follows the register or reset change.

// File: rtl/pmr_pkg.sv
// Package: shared types and reset defaults for the port mode resolver.
// Assumes a single clock domain for all register inputs.
package pmr_pkg;

    // Resolved controls of one port
    typedef struct packed {
        logic fiber;
        logic fef;
        logic mlt3;
        logic scr_byp;
        logic an_en;
        logic sd_en;
        logic ten_en;
        logic carrier;
        logic link_fix;
    } port_ctrl_t;

    // Shared configuration pins captured during reset
    typedef struct packed {
        logic carrier;
        logic scr_byp;
        logic link_fix;
    } shared_strap_t;

    localparam int SHARED_W = $bits(shared_strap_t);

    localparam port_ctrl_t CTRL_DEFAULT = '{
        fiber:    1'b0,
        fef:      1'b0,
        mlt3:     1'b1,
        scr_byp:  1'b0,
        an_en:    1'b0,
        sd_en:    1'b0,
        ten_en:   1'b1,
        carrier:  1'b0,
        link_fix: 1'b1
    };

endpackage

// File: rtl/strap_capture.sv
// strap_capture: follows its input on every clock edge while reset is low,
// then holds the last sampled value until reset is asserted again.
// Assumes the pins are stable for the last cycles of reset.
module strap_capture #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] cap_o
);

    logic rst_q;

    // Sample during reset, hold afterwards
    always_ff @(posedge clk) begin
        if (!rst_n) cap_o <= pin_i;
    end

    // Registered reset level for assertion history
    always_ff @(posedge clk) begin
        rst_q <= rst_n;
    end

    // R10: captured pins stay frozen once reset has been released
    assert_strap_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_q |-> $stable(cap_o));

endmodule

// File: rtl/an_pin_sync.sv
// an_pin_sync: two-stage synchronizer plus one history stage for the
// autonegotiation pin. The chain keeps shifting during reset, so a pin held
// high through reset is seen as steady and gives no edge. Assumes reset
// lasts at least three clocks.
module an_pin_sync (
    input  logic clk,
    input  logic pin_i,
    output logic level_o,
    output logic rise_o
);

    logic [2:0] chain_q;

    // Shift the asynchronous pin through the synchronizer chain
    always_ff @(posedge clk) begin
        chain_q <= {chain_q[1:0], pin_i};
    end

    // Synchronized level and its rising edge
    always_comb begin
        level_o = chain_q[1];
        rise_o  = chain_q[1] & ~chain_q[2];
    end

endmodule

// File: rtl/port_resolver.sv
// port_resolver: resolves the controls of one port from captured pins,
// register bits and the synchronized autonegotiation pin. It applies the
// fiber-mode overrides. Outputs are registered, with defaults in reset.
module port_resolver
    import pmr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strap_fiber_i,
    input  shared_strap_t strap_i,
    input  logic          an_level_i,
    input  logic          an_rise_i,
    input  logic          reg_fiber_i,
    input  logic          reg_carrier_i,
    input  logic          reg_an_en_i,
    input  logic          reg_scr_byp_i,
    input  logic          reg_link_fix_i,
    input  logic          reg_fef_i,
    input  logic          reg_ten_en_i,
    input  logic          sig_det_i,
    output port_ctrl_t    ctrl_o,
    output logic          restart_o
);

    port_ctrl_t next_ctrl;
    logic       next_restart;
    logic       is_fiber;
    logic       rst_q;

    // Combine the sources; fiber mode overrides the copper-only controls
    always_comb begin
        is_fiber           = strap_fiber_i | reg_fiber_i;
        next_ctrl.fiber    = is_fiber;
        next_ctrl.carrier  = strap_i.carrier | reg_carrier_i;
        next_ctrl.link_fix = strap_i.link_fix | reg_link_fix_i;
        if (is_fiber) begin
            next_ctrl.fef     = 1'b1;
            next_ctrl.mlt3    = 1'b0;
            next_ctrl.scr_byp = 1'b1;
            next_ctrl.an_en   = 1'b0;
            next_ctrl.sd_en   = sig_det_i;
            next_ctrl.ten_en  = 1'b0;
            next_restart      = 1'b0;
        end else begin
            next_ctrl.fef     = reg_fef_i;
            next_ctrl.mlt3    = 1'b1;
            next_ctrl.scr_byp = strap_i.scr_byp | reg_scr_byp_i;
            next_ctrl.an_en   = an_level_i & reg_an_en_i;
            next_ctrl.sd_en   = 1'b0;
            next_ctrl.ten_en  = reg_ten_en_i;
            next_restart      = an_rise_i & reg_an_en_i;
        end
    end

    // Register the resolved controls; defaults while in reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_o    <= CTRL_DEFAULT;
            restart_o <= 1'b0;
        end else begin
            ctrl_o    <= next_ctrl;
            restart_o <= next_restart;
        end
    end

    // Registered reset level for assertion history
    always_ff @(posedge clk) begin
        rst_q <= rst_n;
    end

    // R3: a fiber request on the previous edge forces the fixed override set
    assert_fiber_override_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_q && $past(strap_fiber_i | reg_fiber_i)) |->
        (ctrl_o.fef && !ctrl_o.mlt3 && ctrl_o.scr_byp && !ctrl_o.an_en && !ctrl_o.ten_en));

    // R4: signal-detect never reaches a copper port
    assert_sd_copper_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_o.fiber |-> !ctrl_o.sd_en);

    // R7: a restart pulse only appears while autonegotiation is enabled
    assert_restart_needs_an_R7: assert property (@(posedge clk) disable iff (!rst_n)
        restart_o |-> (ctrl_o.an_en && !ctrl_o.fiber));

    // R11: a copper port always uses MLT-3 coding
    assert_copper_mlt3_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_o.fiber |-> ctrl_o.mlt3);

endmodule

// File: rtl/port_mode_resolver.sv
// port_mode_resolver: top level. It captures the shared and per-port
// configuration pins, synchronizes the autonegotiation pin, and builds one
// resolver per port. Assumes all register inputs are synchronous to clk.
module port_mode_resolver
    import pmr_pkg::*;
#(
    parameter int NPORT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPORT-1:0] strap_fiber_i,
    input  logic             strap_carrier_i,
    input  logic             strap_autoneg_i,
    input  logic             strap_scr_byp_i,
    input  logic             strap_link_fix_i,
    input  logic [NPORT-1:0] reg_fiber_i,
    input  logic [NPORT-1:0] reg_carrier_i,
    input  logic [NPORT-1:0] reg_an_en_i,
    input  logic [NPORT-1:0] reg_scr_byp_i,
    input  logic [NPORT-1:0] reg_link_fix_i,
    input  logic [NPORT-1:0] reg_fef_i,
    input  logic [NPORT-1:0] reg_ten_en_i,
    input  logic [NPORT-1:0] sig_det_i,
    output logic [NPORT-1:0] fiber_o,
    output logic [NPORT-1:0] fef_o,
    output logic [NPORT-1:0] mlt3_o,
    output logic [NPORT-1:0] scr_byp_o,
    output logic [NPORT-1:0] an_en_o,
    output logic [NPORT-1:0] sd_o,
    output logic [NPORT-1:0] ten_o,
    output logic [NPORT-1:0] carrier_o,
    output logic [NPORT-1:0] link_fix_o,
    output logic [NPORT-1:0] an_restart_o
);

    localparam int CAP_W = NPORT + SHARED_W;

    logic [CAP_W-1:0] cap_in;
    logic [CAP_W-1:0] cap_q;
    logic [NPORT-1:0] fiber_cap;
    shared_strap_t    shared_cap;
    logic             an_level;
    logic             an_rise;
    port_ctrl_t       ctrl [NPORT];

    // Pack all captured pins into one vector
    always_comb begin
        cap_in     = {strap_fiber_i, strap_carrier_i, strap_scr_byp_i, strap_link_fix_i};
        fiber_cap  = cap_q[CAP_W-1 -: NPORT];
        shared_cap = shared_strap_t'(cap_q[SHARED_W-1:0]);
    end

    strap_capture #(.W(CAP_W)) i_capture (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (cap_in),
        .cap_o (cap_q)
    );

    an_pin_sync i_an_sync (
        .clk     (clk),
        .pin_i   (strap_autoneg_i),
        .level_o (an_level),
        .rise_o  (an_rise)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        port_resolver i_port (
            .clk            (clk),
            .rst_n          (rst_n),
            .strap_fiber_i  (fiber_cap[p]),
            .strap_i        (shared_cap),
            .an_level_i     (an_level),
            .an_rise_i      (an_rise),
            .reg_fiber_i    (reg_fiber_i[p]),
            .reg_carrier_i  (reg_carrier_i[p]),
            .reg_an_en_i    (reg_an_en_i[p]),
            .reg_scr_byp_i  (reg_scr_byp_i[p]),
            .reg_link_fix_i (reg_link_fix_i[p]),
            .reg_fef_i      (reg_fef_i[p]),
            .reg_ten_en_i   (reg_ten_en_i[p]),
            .sig_det_i      (sig_det_i[p]),
            .ctrl_o         (ctrl[p]),
            .restart_o      (an_restart_o[p])
        );

        // Spread the per-port record onto the flat output vectors
        always_comb begin
            fiber_o[p]    = ctrl[p].fiber;
            fef_o[p]      = ctrl[p].fef;
            mlt3_o[p]     = ctrl[p].mlt3;
            scr_byp_o[p]  = ctrl[p].scr_byp;
            an_en_o[p]    = ctrl[p].an_en;
            sd_o[p]       = ctrl[p].sd_en;
            ten_o[p]      = ctrl[p].ten_en;
            carrier_o[p]  = ctrl[p].carrier;
            link_fix_o[p] = ctrl[p].link_fix;
        end
    end

    // R7: a restart pulse never lasts two consecutive clocks
    assert_restart_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|an_restart_o) |=> !(|an_restart_o));

endmodule

// File: tb/test_port_mode_resolver.sv
// Scoreboard bench: the driver computes the expected outputs for each edge
// from the requirements and queues them; the monitor pops and compares.
module test_port_mode_resolver;

    localparam int NP = 8;

    typedef struct {
        logic [NP-1:0] fiber, fef, mlt3, scr, an, sd, ten, car, lfix, rst;
        bit            in_reset;
        string         note;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-1:0] strap_fiber = '0;
    logic s_car = 1'b0, s_an = 1'b0, s_scr = 1'b0, s_lfix = 1'b1;
    logic [NP-1:0] r_fiber = '0, r_car = '0, r_an = '0, r_scr = '0;
    logic [NP-1:0] r_lfix = '0, r_fef = '0, r_ten = '1, sdet = '0;
    wire  [NP-1:0] fiber_o, fef_o, mlt3_o, scr_o, an_o, sd_o, ten_o, car_o, lfix_o, rst_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    exp_t exp_q[$];

    // model state: captured pins and synchronizer stages
    logic [NP-1:0] m_fiber = '0;
    logic m_car = 0, m_scr = 0, m_lfix = 1;
    logic m_s1 = 0, m_s2 = 0, m_s3 = 0;
    string note = "";

    always #2.5 clk = ~clk;

    port_mode_resolver #(.NPORT(NP)) i_port_mode_resolver (
        .clk(clk), .rst_n(rst_n),
        .strap_fiber_i(strap_fiber), .strap_carrier_i(s_car),
        .strap_autoneg_i(s_an), .strap_scr_byp_i(s_scr), .strap_link_fix_i(s_lfix),
        .reg_fiber_i(r_fiber), .reg_carrier_i(r_car), .reg_an_en_i(r_an),
        .reg_scr_byp_i(r_scr), .reg_link_fix_i(r_lfix), .reg_fef_i(r_fef),
        .reg_ten_en_i(r_ten), .sig_det_i(sdet),
        .fiber_o(fiber_o), .fef_o(fef_o), .mlt3_o(mlt3_o), .scr_byp_o(scr_o),
        .an_en_o(an_o), .sd_o(sd_o), .ten_o(ten_o), .carrier_o(car_o),
        .link_fix_o(lfix_o), .an_restart_o(rst_o)
    );

    // Driver: queue the expected values for the coming edge, then take it
    task automatic tick();
        exp_t e;
        logic [NP-1:0] fb;
        e.note = note;
        e.in_reset = !rst_n;
        if (!rst_n) begin
            m_fiber = strap_fiber; m_car = s_car; m_scr = s_scr; m_lfix = s_lfix;
            e.fiber = '0; e.fef = '0; e.mlt3 = '1; e.scr = '0; e.an = '0;
            e.sd = '0; e.ten = '1; e.car = '0; e.lfix = '1; e.rst = '0;
        end else begin
            fb = m_fiber | r_fiber;
            e.fiber = fb;
            e.car   = {NP{m_car}} | r_car;
            e.lfix  = {NP{m_lfix}} | r_lfix;
            e.fef   = fb | r_fef;
            e.mlt3  = ~fb;
            e.scr   = fb | {NP{m_scr}} | r_scr;
            e.an    = ~fb & r_an & {NP{m_s2}};
            e.sd    = fb & sdet;
            e.ten   = ~fb & r_ten;
            e.rst   = ~fb & r_an & {NP{m_s2 & ~m_s3}};
        end
        m_s3 = m_s2; m_s2 = m_s1; m_s1 = s_an;
        exp_q.push_back(e);
        @(posedge clk);
        #1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic cmp(input string tag, input string nt, input logic [NP-1:0] act,
                       input logic [NP-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b", tag, nt, act, exp);
        end
    endtask

    // Monitor: compare outputs away from the active edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            if (e.in_reset) begin
                cmp("R1 fiber", e.note, fiber_o, e.fiber);
                cmp("R1 mlt3", e.note, mlt3_o, e.mlt3);
                cmp("R1 link_fix", e.note, lfix_o, e.lfix);
                cmp("R1 an_en", e.note, an_o, e.an);
                cmp("R1 ten", e.note, ten_o, e.ten);
            end else begin
                cmp("R2 fiber", e.note, fiber_o, e.fiber);
                cmp("R3/R11 fef", e.note, fef_o, e.fef);
                cmp("R3/R11 mlt3", e.note, mlt3_o, e.mlt3);
                cmp("R3/R8 scr_byp", e.note, scr_o, e.scr);
                cmp("R3/R11 ten", e.note, ten_o, e.ten);
                cmp("R4 sd", e.note, sd_o, e.sd);
                cmp("R5 carrier", e.note, car_o, e.car);
                cmp("R6 an_en", e.note, an_o, e.an);
                cmp("R9 link_fix", e.note, lfix_o, e.lfix);
            end
            cmp("R7 restart", e.note, rst_o, e.rst);
            cmp("R1 sd", e.note, sd_o, e.sd);
            cmp("R1 carrier", e.note, car_o, e.car);
        end
    end

    // Stimulus
    initial begin
        note = "reset defaults R1";
        strap_fiber = 8'b0000_1000; s_car = 1; s_scr = 0; s_lfix = 0; s_an = 0;
        ticks(5);
        rst_n = 1;
        note = "copper mix R5 R8 R9 R11";
        r_car = 8'b0000_0011; r_scr = 8'b0101_0000; r_lfix = 8'b1000_0001;
        r_fef = 8'b0010_0100; r_ten = 8'b1111_0000;
        ticks(3);
        note = "fiber via reg overrides R3 R2";
        r_fiber = 8'b0010_0000; r_an = 8'hFF; r_fef = 8'h00; r_scr = 8'h00;
        ticks(2);
        note = "signal detect R4";
        sdet = 8'b1010_1010;
        ticks(3);
        note = "strap pins moved after reset R10";
        strap_fiber = 8'hF0; s_car = 0; s_scr = 1; s_lfix = 1;
        ticks(3);
        note = "autoneg rise and restart R6 R7";
        s_an = 1;
        ticks(6);
        note = "autoneg fall R6";
        s_an = 0;
        ticks(4);
        note = "restart masked by reg R7";
        r_an = 8'b0000_0001;
        s_an = 1;
        ticks(5);
        note = "fiber dropped R2";
        r_fiber = '0; sdet = 8'hFF;
        ticks(3);
        note = "second reset new straps R1 R10";
        rst_n = 0; s_an = 1; strap_fiber = 8'b1000_0000; s_car = 0; s_scr = 1; s_lfix = 0;
        r_car = '0; r_lfix = '0; r_an = 8'hFF;
        ticks(5);
        rst_n = 1;
        note = "after second reset: no restart from held pin R7 R8 R9";
        ticks(5);
        wait (exp_q.size() == 0);
        @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule